// File: doc/BRIEF.md
# Rewindable FIFO with Mark and Retransmit

This block is a synchronous FIFO whose read side can bookmark a position and later jump back to it. All logic runs on one clock. When `mark` is high at a clock edge, the address being read in that cycle is saved as the bookmark. Each cycle that the active-low `rt_n` input is held low, the read pointer is reloaded from the bookmark, so the words from that point are delivered again.

The write side treats every word from the bookmark onward as still occupied. Data that may still be retransmitted can therefore never be overwritten. A new mark moves the bookmark forward and frees the space behind it. Fill count, empty and full are registered. Each edge computes them from the pointer values that the edge loads, so a rewind shows up in the flags and the count right after the edge that performed it.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `empty`=1, `full`=0, `count`=0 and `rd_valid`=0.
- R2: Words are read in the order they were written. A read accepted at an edge puts its word on `rd_data`, with `rd_valid`=1, right after that same edge.
- R3: `count` is the number of unread words between the read pointer and the write pointer. `empty` is 1 exactly when `count` is 0. Both are updated at the edge that changes a pointer.
- R4: A write while `full`=1 is ignored, and the stored data is unchanged. A read while `empty`=1 is ignored, and `rd_valid` stays 0.
- R5: When `mark`=1 at an edge, the address being read in that cycle becomes the bookmark and the bookmark is marked valid. If a read is accepted in the same cycle, the word it delivers is the first word replayed by a later retransmit.
- R6: At an edge where `rt_n`=0 and a bookmark is valid, the read pointer is loaded with the bookmark, and `count` and `empty` right after that edge reflect the restored pointer.
- R7: Every retransmit returns to the same bookmark until a new mark is taken.
- R8: A read and a retransmit in the same cycle resolve as the retransmit alone: `rd_valid` stays 0 and the next read delivers the bookmarked word.
- R9: While a bookmark is valid, `full` is 1 when the write pointer is DEPTH words ahead of the bookmark, even if the live read pointer is further on. Marked data therefore survives further writes.
- R10: A mark taken while the FIFO is empty bookmarks the address of the next word to be written, and the space behind it is released, so `full` drops.
- R11: Reset clears the bookmark-valid bit and sets the bookmark to address 0. With no valid bookmark, `rt_n`=0 has no effect on the read pointer or `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| full | output | 1 | No space relative to bookmark or read pointer |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read word, registered |
| rd_valid | output | 1 | `rd_data` holds a word read at the last edge |
| empty | output | 1 | No unread word |
| count | output | AW+1 | Unread word count |
| mark | input | 1 | Save the current read address as bookmark |
| rt_n | input | 1 | Active-low retransmit |

## Verification
The bench first streams a plain burst through the FIFO. This separates ordering and count errors from anything the bookmark does. It then marks in the middle of a read, drains the FIFO and retransmits twice. These runs show whether the bookmark holds the address being read or the next one, and whether it stays put across repeated rewinds. A read and a retransmit are then driven together, and the bench fills past the live read pointer until `full` rises against the bookmark. This shows whether a blocked write leaves the bookmarked word intact. A mark on an empty FIFO and a retransmit after reset without any mark cover the empty-capture and no-bookmark corners.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  typedef struct packed {
    logic rewind;
    logic take;
    logic fire;
  } rd_evt_t;
endpackage

// File: rtl/rwf_mem.sv
module rwf_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rwf_wrctl.sv
module rwf_wrctl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        full_q,
  output logic        wr_fire,
  output logic [AW:0] wptr,
  output logic [AW:0] wptr_nxt
);
  assign wr_fire  = wr_en && !full_q;
  assign wptr_nxt = wr_fire ? wptr + 1'b1 : wptr;

  always_ff @(posedge clk) begin
    if (rst) wptr <= '0;
    else     wptr <= wptr_nxt;
  end
endmodule

// File: rtl/rwf_rdctl.sv
module rwf_rdctl
  import rwf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  logic        empty_q,
  input  logic        mark,
  input  logic        rt_n,
  output rd_evt_t     evt,
  output logic [AW:0] rptr,
  output logic [AW:0] rptr_nxt,
  output logic [AW:0] mptr_nxt,
  output logic        mvalid_nxt
);
  logic [AW:0] mptr;
  logic        mvalid;

  always_comb begin
    evt.rewind = !rt_n && mvalid;
    evt.fire   = rd_en && !empty_q && !evt.rewind;
    evt.take   = mark && !evt.rewind;
    if (evt.rewind)    rptr_nxt = mptr;
    else if (evt.fire) rptr_nxt = rptr + 1'b1;
    else               rptr_nxt = rptr;
    mptr_nxt   = evt.take ? rptr : mptr;
    mvalid_nxt = mvalid || evt.take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr   <= '0;
      mptr   <= '0;
      mvalid <= 1'b0;
    end else begin
      rptr   <= rptr_nxt;
      mptr   <= mptr_nxt;
      mvalid <= mvalid_nxt;
    end
  end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rwf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic [AW:0]   count,
  input  logic          mark,
  input  logic          rt_n
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

  logic        wr_fire;
  logic [AW:0] wptr, wptr_nxt, rptr, rptr_nxt, mptr_nxt, base_nxt;
  logic        mvalid_nxt;
  rd_evt_t     evt;

  rwf_wrctl #(.AW(AW)) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .full_q(full),
    .wr_fire(wr_fire), .wptr(wptr), .wptr_nxt(wptr_nxt)
  );

  rwf_rdctl #(.AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .empty_q(empty),
    .mark(mark), .rt_n(rt_n), .evt(evt), .rptr(rptr),
    .rptr_nxt(rptr_nxt), .mptr_nxt(mptr_nxt), .mvalid_nxt(mvalid_nxt)
  );

  rwf_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wptr[AW-1:0]), .wdata(wr_data),
    .re(evt.fire), .raddr(rptr[AW-1:0]), .rdata(rd_data)
  );

  assign base_nxt = mvalid_nxt ? mptr_nxt : rptr_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      count    <= wptr_nxt - rptr_nxt;
      empty    <= (wptr_nxt == rptr_nxt);
      full     <= ((wptr_nxt - base_nxt) == DEPTH_V);
      rd_valid <= evt.fire;
    end
  end
endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int AW = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic        rt_n,
  input logic        full,
  input logic        empty,
  input logic        rd_valid,
  input logic [AW:0] count,
  input logic        mvalid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (empty && !full && count == '0 && !rd_valid));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && rt_n) |=> $stable(count));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> !rd_valid);

  // R3
  empty_count_chk: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));

  // R8
  rewind_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_n && mvalid) |=> !rd_valid);

  // R11
  no_mark_rt_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_n && !mvalid && !rd_en && !wr_en) |=> $stable(count));
endmodule

bind rewind_fifo rewind_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rt_n(rt_n),
  .full(full), .empty(empty), .rd_valid(rd_valid), .count(count),
  .mvalid(u_rd.mvalid)
);

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, mark = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty, rd_valid;
  logic [AW:0] count;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rewind_fifo #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
    .count(count), .mark(mark), .rt_n(rt_n)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [DW-1:0] d, input logic r,
                      input logic m, input logic rtn);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; mark = m; rt_n = rtn;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; mark = 1'b0; rt_n = 1'b1;
  endtask

  task automatic rd_expect(input int exp, input string tag);
    step(1'b0, '0, 1'b1, 1'b0, 1'b1);
    chk(rd_valid, 1, tag);
    chk(rd_data, exp, tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(empty, 1, "R1 empty");
    chk(full, 0, "R1 full");
    chk(count, 0, "R1 count");
    chk(rd_valid, 0, "R1 rd_valid");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_basic;
    for (int i = 0; i < 5; i++) step(1'b1, DW'(10 + i), 1'b0, 1'b0, 1'b1);
    chk(count, 5, "R3 count after writes");
    chk(empty, 0, "R3 empty after writes");
    rd_expect(10, "R2 first word");
    rd_expect(11, "R2 second word");
    chk(count, 3, "R3 count after reads");
  endtask

  task automatic t_mark_rt;
    step(1'b0, '0, 1'b1, 1'b1, 1'b1);
    chk(rd_data, 12, "R5 word read with mark");
    rd_expect(13, "R2 after mark");
    rd_expect(14, "R2 last");
    chk(empty, 1, "R3 drained");
    step(1'b0, '0, 1'b1, 1'b0, 1'b1);
    chk(rd_valid, 0, "R4 read when empty");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk(empty, 0, "R6 empty after rewind");
    chk(count, 3, "R6 count after rewind");
    rd_expect(12, "R6 replay first");
    rd_expect(13, "R6 replay second");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk(count, 3, "R7 second rewind count");
    rd_expect(12, "R7 second rewind data");
  endtask

  task automatic t_rd_rt;
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk(rd_valid, 0, "R8 no data on read+rewind");
    chk(count, 3, "R8 count");
    rd_expect(12, "R8 next read is mark");
  endtask

  task automatic t_full_mark;
    rd_expect(13, "R2 drain");
    rd_expect(14, "R2 drain");
    for (int i = 0; i < 5; i++) step(1'b1, DW'(20 + i), 1'b0, 1'b0, 1'b1);
    chk(full, 1, "R9 full against mark");
    chk(count, 5, "R9 count below depth");
    step(1'b1, 8'hEE, 1'b0, 1'b0, 1'b1);
    chk(count, 5, "R4 write when full ignored");
    for (int i = 0; i < 5; i++) rd_expect(20 + i, "R9 new words");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk(count, 8, "R9 rewind count");
    rd_expect(12, "R9 marked word intact");
  endtask

  task automatic t_empty_mark;
    rd_expect(13, "R2 drain");
    rd_expect(14, "R2 drain");
    for (int i = 0; i < 5; i++) rd_expect(20 + i, "R2 drain");
    chk(empty, 1, "R3 empty");
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    chk(full, 0, "R10 full released");
    step(1'b1, 8'h77, 1'b0, 1'b0, 1'b1);
    rd_expect(8'h77, "R10 read new word");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk(count, 1, "R10 rewind to empty mark");
    rd_expect(8'h77, "R10 replay new word");
  endtask

  task automatic t_no_mark;
    t_reset;
    step(1'b1, 8'h31, 1'b0, 1'b0, 1'b1);
    step(1'b1, 8'h32, 1'b0, 1'b0, 1'b1);
    rd_expect(8'h31, "R11 first");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk(count, 1, "R11 rewind without mark ignored");
    rd_expect(8'h32, "R11 pointer unchanged");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_mark_rt;
    t_rd_rt;
    t_full_mark;
    t_empty_mark;
    t_no_mark;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule